// File: doc/BRIEF.md
# Radio Auto-Sleep and Snooze Sequencer

This block decides the power state of a packet radio. When a transmission finishes or a receive attempt ends, it can put the device to sleep on its own. Each direction has its own auto-sleep bit, and both are gated by a global sleep permission. No sleep is entered while an unmasked interrupt is waiting. Sleep has no timer and ends only on an external wake event. On that wake the two auto-sleep bits clear themselves, unless a keep bit is set.

The block also runs a snooze for low-power listening. A snooze is a low-power interval of precise length, timed in reference-clock ticks (19.2 MHz, given as a tick enable). When the snooze ends, the block opens a receive window by raising its receiver-enable request. When the receive attempt in that window completes, the block either starts the next snooze (repeat mode, with no limit on the number of cycles) or returns to idle. The configuration is loaded as one word, and the block presents the live configuration bits, including any that have cleared themselves.

Top module: `radio_pwr_seq`

## Requirements
- R1: After reset, `pwr_state_o` is 0 (idle), `rx_en_o` is 0 and all configuration outputs are 0. The state encoding is idle=0, radio active=1, sleep=2, snooze=3.
- R2: A cycle with `cfg_ld_i` high writes all six configuration inputs to the matching outputs at the next clock edge. In idle, `act_start_i` moves the state to active (1) with `rx_en_o` low.
- R3: In active with `rx_en_o` low, a `tx_done_i` pulse moves the state to sleep (2) when the TX auto-sleep bit and the sleep-enable bit are both set and `irq_pend_i` is low. Otherwise the state moves to idle.
- R4: In active with `rx_en_o` low, an `rx_done_i` pulse does the same as R3, using the RX auto-sleep bit instead of the TX auto-sleep bit.
- R5: With sleep-enable clear, or with `irq_pend_i` high at the completion event, the block goes to idle. It then stays in idle after the interrupt clears, until a new event arrives.
- R6: Sleep is held for any number of cycles until `wake_i`. A `wake_i` in sleep gives idle at the next edge.
- R7: A wake from sleep clears the TX and RX auto-sleep bits when the keep bit is clear. It leaves them unchanged when the keep bit is set. The other configuration bits are not affected.
- R8: In idle, `snz_go_i` enters snooze (3) only when the snooze-enable bit is set. With that bit clear, the pulse is ignored and the state stays idle.
- R9: A snooze lasts exactly max(P,1)*2^PRE_W cycles in which `ref_tick_i` is high. P is `snz_per_i`, sampled when the snooze is entered, and PRE_W defaults to 10. Cycles with `ref_tick_i` low do not count. At the end, the state becomes active with `rx_en_o` high.
- R10: An `rx_done_i` during a receive window starts a new snooze when both snooze-enable and snooze-repeat are set. Otherwise it returns the block to idle with `rx_en_o` low.
- R11: A `wake_i` during snooze gives idle at the next edge. A later snooze counts its full length again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_ld_i | input | 1 | Load the configuration inputs |
| cfg_tx_slp_i | input | 1 | Auto-sleep after transmit |
| cfg_rx_slp_i | input | 1 | Auto-sleep after receive attempt |
| cfg_snz_en_i | input | 1 | Snooze enable |
| cfg_snz_rpt_i | input | 1 | Snooze repeat |
| cfg_slp_en_i | input | 1 | Global sleep permission |
| cfg_keep_i | input | 1 | Keep auto-sleep bits over wake |
| snz_per_i | input | SNZ_W | Snooze length in units of 2^PRE_W ticks |
| ref_tick_i | input | 1 | Reference-clock tick enable |
| act_start_i | input | 1 | Radio activity starts |
| snz_go_i | input | 1 | Start a snooze |
| tx_done_i | input | 1 | Transmission completed |
| rx_done_i | input | 1 | Receive attempt completed |
| irq_pend_i | input | 1 | Unmasked interrupt pending |
| wake_i | input | 1 | Wake event |
| pwr_state_o | output | 2 | Power state |
| rx_en_o | output | 1 | Receiver-enable request (receive window) |
| cfg_tx_slp_o | output | 1 | Live TX auto-sleep bit |
| cfg_rx_slp_o | output | 1 | Live RX auto-sleep bit |
| cfg_snz_en_o | output | 1 | Live snooze enable |
| cfg_snz_rpt_o | output | 1 | Live snooze repeat |
| cfg_slp_en_o | output | 1 | Live sleep permission |
| cfg_keep_o | output | 1 | Live keep bit |

## Verification
The assertions assume that completion, start and wake events are single-cycle pulses that arrive only in the state where they have meaning. They also assume that a configuration load does not land in the same cycle as a wake. The directed tasks drive each pulse for exactly one cycle at the falling edge. A task loads the configuration only while the block is idle or active, and it raises wake only in sleep or snooze. The snooze checks count the cycles spent in state 3 with the tick held steady, so each measured length is an exact product of the loaded period and the prescaler.

// File: rtl/radio_pwr_pkg.sv
package radio_pwr_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_ACTIVE = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_SNOOZE = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic tx_slp;
    logic rx_slp;
    logic snz_en;
    logic snz_rpt;
    logic slp_en;
    logic keep;
  } pwr_cfg_t;
endpackage

// File: rtl/radio_pwr_cfg.sv
module radio_pwr_cfg
  import radio_pwr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ld_i,
  input  pwr_cfg_t wr_i,
  input  logic     wake_clr_i,
  output pwr_cfg_t cfg_o
);
  pwr_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (ld_i) begin
      cfg_q <= wr_i;
    end else if (wake_clr_i && !cfg_q.keep) begin
      cfg_q.tx_slp <= 1'b0;
      cfg_q.rx_slp <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/radio_pwr_snz_timer.sv
module radio_pwr_snz_timer #(
  parameter int SNZ_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [SNZ_W-1:0] per_i,
  output logic             done_o
);
  localparam int CW = SNZ_W + PRE_W;

  logic [CW-1:0]    cnt_q;
  logic [SNZ_W-1:0] per_q;
  logic [SNZ_W-1:0] per_eff;
  logic [CW-1:0]    last;

  // zero period is treated as one unit
  assign per_eff = (per_q == '0) ? SNZ_W'(1) : per_q;
  assign last    = {per_eff, {PRE_W{1'b0}}} - CW'(1);
  assign done_o  = run_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      per_q <= per_i;
    end else if (run_i && tick_i) begin
      cnt_q <= done_o ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/radio_pwr_fsm.sv
module radio_pwr_fsm
  import radio_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_cfg_t   cfg_i,
  input  logic       act_start_i,
  input  logic       snz_go_i,
  input  logic       tx_done_i,
  input  logic       rx_done_i,
  input  logic       irq_pend_i,
  input  logic       wake_i,
  input  logic       snz_done_i,
  output pwr_state_e state_o,
  output logic       win_o,
  output logic       snz_start_o,
  output logic       wake_clr_o
);
  pwr_state_e state_q, state_d;
  logic       win_q, win_d;
  logic       slp_ok;

  assign slp_ok = cfg_i.slp_en && !irq_pend_i;

  always_comb begin
    state_d     = state_q;
    win_d       = win_q;
    snz_start_o = 1'b0;
    wake_clr_o  = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        win_d = 1'b0;
        if (snz_go_i && cfg_i.snz_en) begin
          state_d     = PS_SNOOZE;
          snz_start_o = 1'b1;
        end else if (act_start_i) begin
          state_d = PS_ACTIVE;
        end
      end
      PS_ACTIVE: begin
        if (win_q) begin
          if (rx_done_i) begin
            win_d = 1'b0;
            if (cfg_i.snz_en && cfg_i.snz_rpt) begin
              state_d     = PS_SNOOZE;
              snz_start_o = 1'b1;
            end else begin
              state_d = PS_IDLE;
            end
          end
        end else if (tx_done_i) begin
          state_d = (cfg_i.tx_slp && slp_ok) ? PS_SLEEP : PS_IDLE;
        end else if (rx_done_i) begin
          state_d = (cfg_i.rx_slp && slp_ok) ? PS_SLEEP : PS_IDLE;
        end
      end
      PS_SLEEP: begin
        if (wake_i) begin
          state_d    = PS_IDLE;
          wake_clr_o = 1'b1;
        end
      end
      PS_SNOOZE: begin
        if (wake_i) begin
          state_d = PS_IDLE;
        end else if (snz_done_i) begin
          state_d = PS_ACTIVE;
          win_d   = 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      win_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
    end
  end

  assign state_o = state_q;
  assign win_o   = win_q;
endmodule

// File: rtl/radio_pwr_seq.sv
module radio_pwr_seq
  import radio_pwr_pkg::*;
#(
  parameter int SNZ_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_ld_i,
  input  logic             cfg_tx_slp_i,
  input  logic             cfg_rx_slp_i,
  input  logic             cfg_snz_en_i,
  input  logic             cfg_snz_rpt_i,
  input  logic             cfg_slp_en_i,
  input  logic             cfg_keep_i,
  input  logic [SNZ_W-1:0] snz_per_i,
  input  logic             ref_tick_i,
  input  logic             act_start_i,
  input  logic             snz_go_i,
  input  logic             tx_done_i,
  input  logic             rx_done_i,
  input  logic             irq_pend_i,
  input  logic             wake_i,
  output logic [1:0]       pwr_state_o,
  output logic             rx_en_o,
  output logic             cfg_tx_slp_o,
  output logic             cfg_rx_slp_o,
  output logic             cfg_snz_en_o,
  output logic             cfg_snz_rpt_o,
  output logic             cfg_slp_en_o,
  output logic             cfg_keep_o
);
  pwr_cfg_t   cfg_wr, cfg;
  pwr_state_e state;
  logic       win, snz_start, snz_done, wake_clr;

  assign cfg_wr = '{tx_slp: cfg_tx_slp_i, rx_slp: cfg_rx_slp_i,
                    snz_en: cfg_snz_en_i, snz_rpt: cfg_snz_rpt_i,
                    slp_en: cfg_slp_en_i, keep: cfg_keep_i};

  radio_pwr_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (cfg_ld_i),
    .wr_i       (cfg_wr),
    .wake_clr_i (wake_clr),
    .cfg_o      (cfg)
  );

  radio_pwr_snz_timer #(.SNZ_W(SNZ_W), .PRE_W(PRE_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (snz_start),
    .run_i   (state == PS_SNOOZE),
    .tick_i  (ref_tick_i),
    .per_i   (snz_per_i),
    .done_o  (snz_done)
  );

  radio_pwr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .act_start_i (act_start_i),
    .snz_go_i    (snz_go_i),
    .tx_done_i   (tx_done_i),
    .rx_done_i   (rx_done_i),
    .irq_pend_i  (irq_pend_i),
    .wake_i      (wake_i),
    .snz_done_i  (snz_done),
    .state_o     (state),
    .win_o       (win),
    .snz_start_o (snz_start),
    .wake_clr_o  (wake_clr)
  );

  assign pwr_state_o   = state;
  assign rx_en_o       = (state == PS_ACTIVE) && win;
  assign cfg_tx_slp_o  = cfg.tx_slp;
  assign cfg_rx_slp_o  = cfg.rx_slp;
  assign cfg_snz_en_o  = cfg.snz_en;
  assign cfg_snz_rpt_o = cfg.snz_rpt;
  assign cfg_slp_en_o  = cfg.slp_en;
  assign cfg_keep_o    = cfg.keep;
endmodule

// File: rtl/radio_pwr_seq_chk.sv
module radio_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_ld_i,
  input logic       tx_done_i,
  input logic       rx_done_i,
  input logic       irq_pend_i,
  input logic       wake_i,
  input logic [1:0] pwr_state_o,
  input logic       rx_en_o,
  input logic       cfg_tx_slp_o,
  input logic       cfg_rx_slp_o,
  input logic       cfg_snz_en_o,
  input logic       cfg_snz_rpt_o,
  input logic       cfg_slp_en_o,
  input logic       cfg_keep_o
);
  a_r3_tx_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd1 && !rx_en_o && tx_done_i && cfg_tx_slp_o &&
     cfg_slp_en_o && !irq_pend_i) |=> pwr_state_o == 2'd2);

  a_r4_rx_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd1 && !rx_en_o && !tx_done_i && rx_done_i &&
     cfg_rx_slp_o && cfg_slp_en_o && !irq_pend_i) |=> pwr_state_o == 2'd2);

  a_r5_sleep_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o != 2'd2) |=>
      (pwr_state_o != 2'd2) || ($past(cfg_slp_en_o) && !$past(irq_pend_i)));

  a_r6_sleep_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2 && !wake_i) |=> pwr_state_o == 2'd2);

  a_r6_wake_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2 && wake_i) |=> pwr_state_o == 2'd0);

  a_r7_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2 && wake_i && !cfg_keep_o && !cfg_ld_i) |=>
      (!cfg_tx_slp_o && !cfg_rx_slp_o));

  a_r7_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2 && wake_i && cfg_keep_o && !cfg_ld_i) |=>
      ($stable(cfg_tx_slp_o) && $stable(cfg_rx_slp_o)));

  a_r9_snooze_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd3 && !wake_i) |=> (pwr_state_o == 2'd3 || rx_en_o));

  a_r10_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o && rx_done_i && cfg_snz_en_o && cfg_snz_rpt_o) |=>
      pwr_state_o == 2'd3);

  a_r11_wake_snooze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd3 && wake_i) |=> (pwr_state_o == 2'd0 && !rx_en_o));
endmodule

bind radio_pwr_seq radio_pwr_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_ld_i      (cfg_ld_i),
  .tx_done_i     (tx_done_i),
  .rx_done_i     (rx_done_i),
  .irq_pend_i    (irq_pend_i),
  .wake_i        (wake_i),
  .pwr_state_o   (pwr_state_o),
  .rx_en_o       (rx_en_o),
  .cfg_tx_slp_o  (cfg_tx_slp_o),
  .cfg_rx_slp_o  (cfg_rx_slp_o),
  .cfg_snz_en_o  (cfg_snz_en_o),
  .cfg_snz_rpt_o (cfg_snz_rpt_o),
  .cfg_slp_en_o  (cfg_slp_en_o),
  .cfg_keep_o    (cfg_keep_o)
);

// File: tb/radio_pwr_seq_tb_top.sv
module radio_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SNZ_W = 8;
  localparam int PRE_W = 10;
  localparam int UNIT  = 1 << PRE_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_ld = 0, c_tx = 0, c_rx = 0, c_sen = 0, c_srp = 0, c_slp = 0, c_keep = 0;
  logic [SNZ_W-1:0] per = '0;
  logic tick = 0, act = 0, go = 0, txd = 0, rxd = 0, irq = 0, wake = 0;
  logic [1:0] st;
  logic rx_en, o_tx, o_rx, o_sen, o_srp, o_slp, o_keep;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_pwr_seq #(.SNZ_W(SNZ_W), .PRE_W(PRE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_ld_i(cfg_ld),
    .cfg_tx_slp_i(c_tx), .cfg_rx_slp_i(c_rx), .cfg_snz_en_i(c_sen),
    .cfg_snz_rpt_i(c_srp), .cfg_slp_en_i(c_slp), .cfg_keep_i(c_keep),
    .snz_per_i(per), .ref_tick_i(tick), .act_start_i(act), .snz_go_i(go),
    .tx_done_i(txd), .rx_done_i(rxd), .irq_pend_i(irq), .wake_i(wake),
    .pwr_state_o(st), .rx_en_o(rx_en), .cfg_tx_slp_o(o_tx),
    .cfg_rx_slp_o(o_rx), .cfg_snz_en_o(o_sen), .cfg_snz_rpt_o(o_srp),
    .cfg_slp_en_o(o_slp), .cfg_keep_o(o_keep)
  );

  task automatic chk(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic load_cfg(input logic tx, rx, sen, srp, slp, keep);
    @(negedge clk);
    {c_tx, c_rx, c_sen, c_srp, c_slp, c_keep} = {tx, rx, sen, srp, slp, keep};
    cfg_ld = 1;
    @(negedge clk);
    cfg_ld = 0;
  endtask

  // drive for one cycle; outputs sampled at the following negedge
  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1;
    @(negedge clk);
    sig = 0;
  endtask

  task automatic count_snooze(output int n);
    n = 0;
    while (st == 2'd3 && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 state", st, 0);
    chk("R1 rx_en", rx_en, 0);
    chk("R1 cfg", {o_tx, o_rx, o_sen, o_srp, o_slp, o_keep}, 0);
  endtask

  task automatic t_cfg_load();
    load_cfg(1, 0, 1, 0, 1, 0);
    chk("R2 cfg", {o_tx, o_rx, o_sen, o_srp, o_slp, o_keep}, 6'b101010);
    load_cfg(0, 1, 0, 1, 0, 1);
    chk("R2 cfg", {o_tx, o_rx, o_sen, o_srp, o_slp, o_keep}, 6'b010101);
    pulse(act);
    chk("R2 active", st, 1);
    chk("R2 rx_en", rx_en, 0);
    pulse(txd);
    chk("R2 back idle", st, 0);
  endtask

  task automatic t_tx_sleep();
    load_cfg(1, 1, 1, 0, 1, 0);
    pulse(act);
    pulse(txd);
    chk("R3 tx sleep", st, 2);
    repeat (20) @(negedge clk);
    chk("R6 sleep held", st, 2);
    pulse(wake);
    chk("R6 wake idle", st, 0);
    chk("R7 tx cleared", o_tx, 0);
    chk("R7 rx cleared", o_rx, 0);
    chk("R7 others kept", {o_sen, o_slp}, 2'b11);
  endtask

  task automatic t_rx_sleep();
    load_cfg(0, 1, 0, 0, 1, 1);
    pulse(act);
    pulse(txd);
    chk("R3 tx bit clear no sleep", st, 0);
    pulse(act);
    pulse(rxd);
    chk("R4 rx sleep", st, 2);
    pulse(wake);
    chk("R6 wake idle", st, 0);
    chk("R7 keep rx", o_rx, 1);
    chk("R7 keep tx", o_tx, 0);
  endtask

  task automatic t_gating();
    load_cfg(1, 1, 0, 0, 0, 0);
    pulse(act);
    pulse(txd);
    chk("R5 no slp_en", st, 0);
    load_cfg(1, 1, 0, 0, 1, 0);
    pulse(act);
    irq = 1;
    pulse(rxd);
    chk("R5 irq blocks", st, 0);
    irq = 0;
    repeat (10) @(negedge clk);
    chk("R5 no retry", st, 0);
  endtask

  task automatic t_snz_off();
    load_cfg(0, 0, 0, 0, 1, 0);
    pulse(go);
    chk("R8 ignored", st, 0);
  endtask

  task automatic t_snooze_single();
    int n;
    load_cfg(0, 0, 1, 0, 1, 0);
    per = 8'd1;
    tick = 1;
    pulse(go);
    chk("R8 snooze", st, 3);
    count_snooze(n);
    chk("R9 len p1", n, UNIT);
    chk("R9 window", st, 1);
    chk("R9 rx_en", rx_en, 1);
    pulse(rxd);
    chk("R10 single end", st, 0);
    chk("R10 rx_en low", rx_en, 0);
    // stall with tick low, period 2
    per = 8'd2;
    tick = 0;
    pulse(go);
    per = 8'd7;
    repeat (50) @(negedge clk);
    chk("R9 stalled", st, 3);
    tick = 1;
    count_snooze(n);
    chk("R9 len p2 stalled", n, 2 * UNIT);
    pulse(rxd);
    per = 8'd0;
    pulse(go);
    count_snooze(n);
    chk("R9 len p0", n, UNIT);
    pulse(rxd);
    chk("R10 idle", st, 0);
  endtask

  task automatic t_snooze_repeat();
    int n;
    load_cfg(0, 0, 1, 1, 1, 0);
    per = 8'd1;
    tick = 1;
    pulse(go);
    count_snooze(n);
    chk("R9 rpt first", n, UNIT);
    pulse(rxd);
    chk("R10 repeat", st, 3);
    count_snooze(n);
    chk("R10 second len", n, UNIT);
    chk("R10 second window", rx_en, 1);
    load_cfg(0, 0, 1, 0, 1, 0);
    pulse(rxd);
    chk("R10 stop repeat", st, 0);
  endtask

  task automatic t_snooze_wake();
    int n;
    load_cfg(0, 0, 1, 0, 1, 0);
    per = 8'd1;
    tick = 1;
    pulse(go);
    repeat (100) @(negedge clk);
    pulse(wake);
    chk("R11 wake idle", st, 0);
    chk("R11 rx_en", rx_en, 0);
    pulse(go);
    count_snooze(n);
    chk("R11 fresh len", n, UNIT);
    pulse(rxd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_cfg_load();
    t_tx_sleep();
    t_rx_sleep();
    t_gating();
    t_snz_off();
    t_snooze_single();
    t_snooze_repeat();
    t_snooze_wake();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule